// File: doc/BRIEF.md
# Bus Selection Detector with Sticky Latch

This block watches the control and data lines of a parallel peripheral bus and decides when an initiator has selected this device as a target. It checks for the select line asserted, the busy line released and no bus reset in progress. It also requires the data lines to carry exactly one ID that is enabled in an 8-bit enable mask, plus at most one other ID bit, which is normally the initiator's own. That condition must hold for a programmed number of consecutive clocks. With the fast setting cleared the count is 43 clocks, about 400 ns at 108 MHz; with it set the count is 5 clocks.

When the qualification count expires, the block latches a selected flag and the index of the matching enabled ID, and it raises a one-clock interrupt pulse. The latch is sticky, so an initiator that drops select a few hundred nanoseconds later, without waiting for busy, is still recorded. A rising bus reset sets its own sticky status bit and also pulses the interrupt. Software clears both status bits with an acknowledge strobe. A software-written busy-control bit drives the bus busy line; writing zero releases it, and a bus reset also forces it off.

Top module: `bus_select_detector`

## Requirements
- R1: Selection qualifies only in a cycle where bus_sel_i=1, bus_bsy_i=0 and bus_rst_i=0, and the data lines have exactly one bit set among those enabled in id_enable_i (bit n enables ID n) and no more than two bits set in total. Otherwise the qualification count does not advance.
- R2: With fast_qual_i=0, selected_o becomes 1 right after the 43rd consecutive qualifying clock edge, and not earlier.
- R3: With fast_qual_i=1, selected_o becomes 1 right after the 5th consecutive qualifying clock edge.
- R4: A single non-qualifying cycle restarts the count from zero.
- R5: Once set, selected_o stays 1 after bus_sel_i is released, and sel_id_o holds the bit position (0 to 7) of the enabled ID that matched.
- R6: irq_o is a one-cycle pulse, given in the same cycle selected_o first rises. A qualification that completes while selected_o is already 1 gives no pulse.
- R7: A one-cycle ack_i clears selected_o and bus_reset_o on the next clock edge.
- R8: A rising edge of bus_rst_i sets bus_reset_o and pulses irq_o on the next clock edge. While bus_rst_i is 1, selected_o is cleared, and a bus reset that stays high gives no further pulses.
- R9: bsy_wr_i loads bsy_wdata_i into bsy_drive_o on the next clock edge. bus_rst_i=1 forces bsy_drive_o to 0 and takes priority over a write.
- R10: After rst_n is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus select line, 1 = asserted |
| bus_bsy_i | input | 1 | Bus busy line, 1 = asserted |
| bus_rst_i | input | 1 | Bus reset line, 1 = asserted |
| bus_data_i | input | 8 | Bus data lines, one bit per ID |
| id_enable_i | input | 8 | Enabled target IDs, bit n = ID n |
| fast_qual_i | input | 1 | 1 = 5-clock qualification, 0 = 43-clock |
| ack_i | input | 1 | Software acknowledge, clears status |
| bsy_wr_i | input | 1 | Write strobe for the busy-control bit |
| bsy_wdata_i | input | 1 | Value written to the busy-control bit |
| selected_o | output | 1 | Sticky selected status |
| sel_id_o | output | 3 | Index of the enabled ID that was selected |
| bus_reset_o | output | 1 | Sticky bus-reset status |
| irq_o | output | 1 | One-cycle interrupt pulse |
| bsy_drive_o | output | 1 | Drive for the bus busy line |

## Verification
The bench targets the exact expiry cycle in both delay settings. A design with an off-by-one counter would latch one clock early or late against the reference. It breaks a run of qualifying cycles with a single idle cycle, which catches a counter that holds its value instead of restarting. It presents patterns that must be rejected: two enabled IDs, three bits set, no enabled ID, busy asserted and reset asserted. A loose match would select on one of them. It also drops select right after the latch, lets a qualification complete while already selected, and holds bus reset high for several cycles. A non-sticky latch, a repeated interrupt or a level-triggered reset pulse would show up as a mismatch in these cases.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // Sampled bus control lines, 1 = asserted
  typedef struct packed {
    logic sel;
    logic bsy;
    logic rst;
  } bus_ctl_t;

  typedef enum logic {
    QUAL_DEFAULT = 1'b0,
    QUAL_FAST    = 1'b1
  } qual_mode_e;
endpackage

// File: rtl/bsel_match.sv
module bsel_match #(
  parameter int ID_W  = 8,
  localparam int IDX_W = $clog2(ID_W),
  localparam int CW    = $clog2(ID_W + 1)
) (
  input  logic [ID_W-1:0]  data_i,
  input  logic [ID_W-1:0]  enable_i,
  output logic             match_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [ID_W-1:0] hit_bits;
  logic [CW-1:0]   n_all;
  logic [CW-1:0]   n_hit;

  assign hit_bits = data_i & enable_i;

  always_comb begin
    n_all = '0;
    n_hit = '0;
    idx_o = '0;
    for (int i = 0; i < ID_W; i++) begin
      n_all = n_all + CW'(data_i[i]);
      n_hit = n_hit + CW'(hit_bits[i]);
      if (hit_bits[i]) idx_o = IDX_W'(i);
    end
  end

  // one enabled ID, plus at most one other (initiator) bit
  assign match_o = (n_hit == CW'(1)) && (n_all <= CW'(2));
endmodule

// File: rtl/bsel_qual_timer.sv
module bsel_qual_timer #(
  parameter int DEF_QUAL  = 43,
  parameter int FAST_QUAL = 5,
  localparam int MAXQ  = (DEF_QUAL > FAST_QUAL) ? DEF_QUAL : FAST_QUAL,
  localparam int CNT_W = $clog2(MAXQ + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  bsel_pkg::qual_mode_e mode_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] DEF_M1  = CNT_W'(DEF_QUAL - 1);
  localparam logic [CNT_W-1:0] FAST_M1 = CNT_W'(FAST_QUAL - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAXQ);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last;

  assign last     = (mode_i == bsel_pkg::QUAL_FAST) ? FAST_M1 : DEF_M1;
  assign expire_o = cond_i && (cnt_q == last);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!cond_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bsel_status.sv
module bsel_status #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bus_rst_i,
  input  logic             ack_i,
  input  logic             bsy_wr_i,
  input  logic             bsy_wdata_i,
  output logic             selected_o,
  output logic [IDX_W-1:0] sel_id_o,
  output logic             bus_reset_o,
  output logic             irq_o,
  output logic             bsy_drive_o
);
  logic             sel_q, sel_d;
  logic [IDX_W-1:0] id_q;
  logic             brs_q, brs_d;
  logic             irq_q, irq_d;
  logic             bsy_q, bsy_d;
  logic             rst_seen_q;
  logic             rst_rise, take;

  assign rst_rise = bus_rst_i && !rst_seen_q;
  assign take     = expire_i && !sel_q;

  always_comb begin
    sel_d = sel_q;
    if (bus_rst_i)  sel_d = 1'b0;
    else if (take)  sel_d = 1'b1;
    else if (ack_i) sel_d = 1'b0;

    brs_d = brs_q;
    if (rst_rise)   brs_d = 1'b1;
    else if (ack_i) brs_d = 1'b0;

    irq_d = take || rst_rise;

    bsy_d = bsy_q;
    if (bus_rst_i)     bsy_d = 1'b0;
    else if (bsy_wr_i) bsy_d = bsy_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      id_q       <= '0;
      brs_q      <= 1'b0;
      irq_q      <= 1'b0;
      bsy_q      <= 1'b0;
      rst_seen_q <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      brs_q      <= brs_d;
      irq_q      <= irq_d;
      bsy_q      <= bsy_d;
      rst_seen_q <= bus_rst_i;
      if (take) id_q <= idx_i;
    end
  end

  assign selected_o  = sel_q;
  assign sel_id_o    = id_q;
  assign bus_reset_o = brs_q;
  assign irq_o       = irq_q;
  assign bsy_drive_o = bsy_q;
endmodule

// File: rtl/bus_select_detector.sv
module bus_select_detector #(
  parameter int ID_W      = 8,
  parameter int DEF_QUAL  = 43,
  parameter int FAST_QUAL = 5,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel_i,
  input  logic             bus_bsy_i,
  input  logic             bus_rst_i,
  input  logic [ID_W-1:0]  bus_data_i,
  input  logic [ID_W-1:0]  id_enable_i,
  input  logic             fast_qual_i,
  input  logic             ack_i,
  input  logic             bsy_wr_i,
  input  logic             bsy_wdata_i,
  output logic             selected_o,
  output logic [IDX_W-1:0] sel_id_o,
  output logic             bus_reset_o,
  output logic             irq_o,
  output logic             bsy_drive_o
);
  import bsel_pkg::*;

  bus_ctl_t         ctl;
  qual_mode_e       mode;
  logic             id_match;
  logic [IDX_W-1:0] id_idx;
  logic             qualify;
  logic             expire;

  assign ctl     = '{sel: bus_sel_i, bsy: bus_bsy_i, rst: bus_rst_i};
  assign mode    = fast_qual_i ? QUAL_FAST : QUAL_DEFAULT;
  assign qualify = ctl.sel && !ctl.bsy && !ctl.rst && id_match;

  bsel_match #(.ID_W(ID_W)) u_match (
    .data_i   (bus_data_i),
    .enable_i (id_enable_i),
    .match_o  (id_match),
    .idx_o    (id_idx)
  );

  bsel_qual_timer #(.DEF_QUAL(DEF_QUAL), .FAST_QUAL(FAST_QUAL)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (qualify),
    .mode_i   (mode),
    .expire_o (expire)
  );

  bsel_status #(.IDX_W(IDX_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_i    (expire),
    .idx_i       (id_idx),
    .bus_rst_i   (bus_rst_i),
    .ack_i       (ack_i),
    .bsy_wr_i    (bsy_wr_i),
    .bsy_wdata_i (bsy_wdata_i),
    .selected_o  (selected_o),
    .sel_id_o    (sel_id_o),
    .bus_reset_o (bus_reset_o),
    .irq_o       (irq_o),
    .bsy_drive_o (bsy_drive_o)
  );
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int DEF_QUAL  = 43,
  parameter int FAST_QUAL = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bus_sel_i,
  input logic bus_bsy_i,
  input logic bus_rst_i,
  input logic fast_qual_i,
  input logic selected_o,
  input logic irq_o,
  input logic bus_reset_o,
  input logic bsy_drive_o
);
  localparam logic [15:0] DEF_L  = 16'(DEF_QUAL);
  localparam logic [15:0] FAST_L = 16'(FAST_QUAL);

  // consecutive cycles of select-without-busy, independent of the ID match
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bus_sel_i && !bus_bsy_i && !bus_rst_i) begin
      if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
    end else run_q <= '0;
  end

  // R1: a new selection needs the control lines in qualifying state just before
  a_r1_ctl_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> $past(bus_sel_i && !bus_bsy_i && !bus_rst_i));

  // R2 / R3: never earlier than the programmed delay
  a_r2_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> (run_q >= ($past(fast_qual_i) ? FAST_L : DEF_L)));

  // R6: new selection comes with an interrupt pulse
  a_r6_irq_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> irq_o);

  // R8: reset edge sets status and interrupt
  a_r8_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_i) |=> (bus_reset_o && irq_o));

  // R8: selected cleared while bus reset is active
  a_r8_reset_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !selected_o);

  // R9: bus reset releases the busy drive
  a_r9_reset_releases_bsy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !bsy_drive_o);
endmodule

bind bus_select_detector bsel_checker #(
  .DEF_QUAL(DEF_QUAL), .FAST_QUAL(FAST_QUAL)
) u_bsel_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel_i   (bus_sel_i),
  .bus_bsy_i   (bus_bsy_i),
  .bus_rst_i   (bus_rst_i),
  .fast_qual_i (fast_qual_i),
  .selected_o  (selected_o),
  .irq_o       (irq_o),
  .bus_reset_o (bus_reset_o),
  .bsy_drive_o (bsy_drive_o)
);

// File: tb/tb_bus_select_detector.sv
`timescale 1ns/1ps
module tb_bus_select_detector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, bsy, brst, fast, ack, bwr, bwd;
  logic [7:0] data, mask;
  logic       selected, bus_reset, irq, bsy_drv;
  logic [2:0] sel_id;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bus_select_detector dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_bsy_i(bsy),
    .bus_rst_i(brst), .bus_data_i(data), .id_enable_i(mask),
    .fast_qual_i(fast), .ack_i(ack), .bsy_wr_i(bwr), .bsy_wdata_i(bwd),
    .selected_o(selected), .sel_id_o(sel_id), .bus_reset_o(bus_reset),
    .irq_o(irq), .bsy_drive_o(bsy_drv)
  );

  // ---------------- behavioural reference ----------------
  int m_run, m_id, m_lim;
  bit m_sel, m_brs, m_irq, m_bsy, m_rq, m_q, m_hit, m_rise;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_id = 0; m_sel = 0; m_brs = 0; m_irq = 0; m_bsy = 0; m_rq = 0;
    end else begin
      m_q = sel && !bsy && !brst && ($countones(data & mask) == 1) &&
            ($countones(data) <= 2);
      m_run  = m_q ? m_run + 1 : 0;
      m_lim  = fast ? 5 : 43;
      m_hit  = m_q && (m_run == m_lim) && !m_sel;
      m_rise = brst && !m_rq;
      m_rq   = brst;
      if (m_hit) for (int i = 0; i < 8; i++) if (data[i] && mask[i]) m_id = i;
      if (brst) m_sel = 0; else if (m_hit) m_sel = 1; else if (ack) m_sel = 0;
      if (m_rise) m_brs = 1; else if (ack) m_brs = 0;
      m_irq = m_hit || m_rise;
      if (brst) m_bsy = 0; else if (bwr) m_bsy = bwd;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R5 cmp selected", selected, m_sel);
    chk("R5 cmp sel_id", sel_id, m_id);
    chk("R6 cmp irq", irq, m_irq);
    chk("R8 cmp bus_reset", bus_reset, m_brs);
    chk("R9 cmp bsy_drive", bsy_drv, m_bsy);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic s, logic b, logic [7:0] d);
    sel = s; bsy = b; data = d;
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; sel = 0; bsy = 0; brst = 0; data = 0; mask = 0;
    fast = 0; ack = 0; bwr = 0; bwd = 0;
    cyc(3);
    chk("R10 reset selected", selected, 0);
    chk("R10 reset sel_id", sel_id, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset bus_reset", bus_reset, 0);
    chk("R10 reset bsy_drive", bsy_drv, 0);
    rst_n = 1;
    cyc(2);

    // default delay: target ID 2, initiator ID 7
    mask = 8'h04;
    drive(1, 0, 8'h84);
    cyc(42);
    chk("R2 not before 43", selected, 0);
    cyc(1);
    chk("R2 set at 43", selected, 1);
    chk("R6 irq with select", irq, 1);
    chk("R5 id index", sel_id, 2);
    cyc(1);
    chk("R6 irq one cycle", irq, 0);
    drive(0, 0, 8'h00);
    cyc(5);
    chk("R5 sticky after release", selected, 1);
    pulse_ack();
    chk("R7 ack clears selected", selected, 0);

    // fast delay with a one-cycle gap
    fast = 1; mask = 8'h20;
    drive(1, 0, 8'h21); cyc(4);
    drive(0, 0, 8'h21); cyc(1);
    drive(1, 0, 8'h21); cyc(4);
    chk("R4 restart after gap", selected, 0);
    cyc(1);
    chk("R3 fast set at 5", selected, 1);
    chk("R3 fast id", sel_id, 5);

    // requalify while already selected: no new pulse
    drive(0, 0, 8'h00); cyc(1);
    drive(1, 0, 8'h21); cyc(5);
    chk("R6 no pulse when already selected", irq, 0);
    drive(0, 0, 8'h00);
    pulse_ack();
    cyc(2);

    // rejected patterns
    drive(1, 1, 8'h21); cyc(10);
    chk("R1 busy blocks", selected, 0);
    mask = 8'h30; drive(1, 0, 8'h30); cyc(10);
    chk("R1 two enabled IDs", selected, 0);
    mask = 8'h20; drive(1, 0, 8'h23); cyc(10);
    chk("R1 three bits", selected, 0);
    drive(1, 0, 8'h01); cyc(10);
    chk("R1 no enabled ID", selected, 0);
    brst = 1; drive(1, 0, 8'h21); cyc(10);
    chk("R1 reset blocks", selected, 0);
    brst = 0; drive(0, 0, 8'h00); pulse_ack(); cyc(2);
    drive(1, 0, 8'h20); cyc(5);
    chk("R1 lone target bit", selected, 1);
    drive(0, 0, 8'h00);

    // busy control
    bwr = 1; bwd = 1; cyc(1); bwr = 0;
    chk("R9 write one", bsy_drv, 1);
    bwr = 1; bwd = 0; cyc(1); bwr = 0;
    chk("R9 write zero", bsy_drv, 0);
    bwr = 1; bwd = 1; cyc(1); bwr = 0;
    cyc(2);

    // bus reset while selected and driving busy; write in the same cycle
    brst = 1; bwr = 1; bwd = 1; cyc(1); bwr = 0;
    chk("R8 reset status", bus_reset, 1);
    chk("R8 reset irq", irq, 1);
    chk("R8 reset clears selected", selected, 0);
    chk("R9 reset releases busy", bsy_drv, 0);
    cyc(3);
    chk("R8 held reset no repulse", irq, 0);
    brst = 0; cyc(1);
    pulse_ack();
    chk("R7 ack clears reset status", bus_reset, 0);
    cyc(3);
    summary();
  end
endmodule